// File: doc/BRIEF.md
# Cascaded Three-Channel Interval Timer

This block holds three 16-bit down-counters behind one byte-wide register port. Channel 2 runs from a master clock-enable input and acts as a prescaler. Its terminal pulse is the only count enable for channels 0 and 1. Channel 0 is meant to divide that stream into a periodic tick interrupt. Channel 1 is meant to hold full scale, so that it wraps and serves as a free-running timebase that software can sample.

Software selects a channel and a mode with a control byte, then loads a count as two byte writes. It can freeze any channel's count with a latch command and read the frozen value back a byte at a time. Each of the two interrupt outputs is a sticky flag that stays high until a write-one-to-clear register acknowledges it.

Top module: `tick_timer3`

## Requirements
- R1: After reset both interrupt outputs are low, every channel is idle and every count reads back as 0x0000.
- R2: The address map is: 0, 1 and 2 for channel data, 3 for control and 4 for interrupt clear. A control byte holds the channel in bits [7:6], the access type in bits [5:4] (2'b11 means 16-bit word, 2'b00 means latch) and the mode in bits [3:1]. A word-access control write stops its channel. The count is loaded low byte first, then high byte, and the channel starts counting only after the high byte is written.
- R3: In rate-generator mode (mode 3'b010) a channel with reload N decrements once per enable. On an enable that finds the count at 1, it reloads N and issues a one-enable-wide terminal pulse, so it pulses once every N enables (N ≥ 2).
- R4: Channel 2 counts on the master enable. Channels 0 and 1 count only on channel 2's terminal pulse. With divisors D on channel 2 and N on channel 0, the tick interrupt goes high exactly after D·N master enables from load.
- R5: A latch command (access 2'b00) freezes the channel's count. Data reads then return the low byte and then the high byte. A second latch command is ignored until both bytes have been read.
- R6: A word-access control write with any mode other than 3'b010 stops the channel, and its count holds while enables continue.
- R7: Channel 0 and channel 1 terminal pulses set sticky flags on the tick and timebase interrupt outputs. Writing a 1 to bit 0 of the clear register clears the tick flag, and a 1 in bit 1 clears the timebase flag. A terminal pulse in the same cycle as a clear leaves the flag set.
- R8: Channel 1 loaded with 0xFFFF and channel 2 at divisor 2 raises the timebase interrupt after exactly 65535·2 master enables.
- R9: While the master enable is low, no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Master count enable, clocks channel 2 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, advances the byte pointer |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for the addressed channel |
| irq_tick | output | 1 | Sticky interrupt from channel 0 |
| irq_base | output | 1 | Sticky interrupt from channel 1 |

## Verification
The cascade is driven with random prescaler and tick divisors. The bench checks that the interrupt is still low one master enable before D·N and high at D·N, which exposes an off-by-one in either stage or a broken chain. Directed stepping with the master enable gated shows several things in turn: a half-written count does not start, the reload happens at 1 rather than at 0, a held latch survives further counting, and a stopped channel stays still. Clear-register patterns 0x01, 0x02 and 0x03 are issued with both flags set, and a clear is aimed at the exact cycle of a terminal pulse. A full 0xFFFF wrap on channel 1 checks the timebase period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 2 * BYTE_W;
  localparam int NUM_CH   = 3;
  localparam int PRE_CH   = 2;
  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd4;
  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_WORD  = 2'b11;
  localparam logic [2:0] MODE_RATE = 3'b010;

  // terminal condition of a rate generator
  function automatic logic f_is_term(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  // one step of a down-counter, wrapping below zero
  function automatic logic [CNT_W-1:0] f_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  // byte of a 16-bit word picked by the read pointer
  function automatic logic [BYTE_W-1:0] f_pick(input logic [CNT_W-1:0] w, input logic hi);
    return hi ? w[CNT_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              ctl_wr,
  input  logic [1:0]        ctl_acc,
  input  logic [2:0]        ctl_mode,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              term_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o
);
  logic [CNT_W-1:0]  cnt, rld, snap;
  logic [BYTE_W-1:0] lo_buf;
  logic run, rate, wr_hi, rd_hi, held;

  assign term_o = run && step_en && f_is_term(cnt);
  assign rdata  = f_pick(held ? snap : cnt, rd_hi);
  assign cnt_o  = cnt;
  assign rld_o  = rld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; rld <= '0; snap <= '0; lo_buf <= '0;
      run <= 1'b0; rate <= 1'b0; wr_hi <= 1'b0; rd_hi <= 1'b0; held <= 1'b0;
    end else begin
      if (ctl_wr) begin
        if (ctl_acc == ACC_LATCH) begin
          if (!held) begin
            held  <= 1'b1;
            snap  <= cnt;
            rd_hi <= 1'b0;
          end
        end else if (ctl_acc == ACC_WORD) begin
          rate  <= (ctl_mode == MODE_RATE);
          run   <= 1'b0;
          wr_hi <= 1'b0;
        end
      end
      if (dat_wr) begin
        if (!wr_hi) begin
          lo_buf <= wdata;
          wr_hi  <= 1'b1;
        end else begin
          rld   <= {wdata, lo_buf};
          cnt   <= {wdata, lo_buf};
          run   <= rate;
          wr_hi <= 1'b0;
        end
      end else if (term_o) begin
        cnt <= rld;
      end else if (run && step_en) begin
        cnt <= f_dec(cnt);
      end
      if (dat_rd) begin
        rd_hi <= !rd_hi;
        if (rd_hi && held) held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i || (flag_o && !clr_i);
  end
endmodule

// File: rtl/tick_timer3.sv
module tick_timer3
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq_tick,
  output logic              irq_base
);
  logic [NUM_CH-1:0] pulse_w;
  logic [BYTE_W-1:0] rd_w  [NUM_CH];
  logic [CNT_W-1:0]  cnt_w [NUM_CH];
  logic [CNT_W-1:0]  rld_w [NUM_CH];
  logic [1:0]        irq_w;
  logic              clr_wr;

  assign clr_wr = wr_en && (addr == ADDR_CLR);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic en_i;
    if (i == PRE_CH) begin : g_pre
      assign en_i = tick_en;
    end else begin : g_cas
      assign en_i = pulse_w[PRE_CH];
    end
    tmr_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (en_i),
      .ctl_wr  (wr_en && (addr == ADDR_CTRL) && (wdata[7:6] == 2'(i))),
      .ctl_acc (wdata[5:4]),
      .ctl_mode(wdata[3:1]),
      .dat_wr  (wr_en && (addr == ADDR_W'(i))),
      .dat_rd  (rd_en && (addr == ADDR_W'(i))),
      .wdata   (wdata),
      .rdata   (rd_w[i]),
      .term_o  (pulse_w[i]),
      .cnt_o   (cnt_w[i]),
      .rld_o   (rld_w[i])
    );
  end

  for (genvar j = 0; j < 2; j++) begin : g_irq
    tmr_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (pulse_w[j]),
      .clr_i (clr_wr && wdata[j]),
      .flag_o(irq_w[j])
    );
  end

  assign irq_tick = irq_w[0];
  assign irq_base = irq_w[1];

  always_comb begin
    case (addr)
      3'd0:    rdata = rd_w[0];
      3'd1:    rdata = rd_w[1];
      3'd2:    rdata = rd_w[2];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer3_chk.sv
module tick_timer3_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_en,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [7:0]  wdata,
  input logic        irq_tick,
  input logic        p0,
  input logic        p2,
  input logic [15:0] cnt0,
  input logic [15:0] cnt2,
  input logic [15:0] rld2
);
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    p0 |=> irq_tick);
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tick && !(wr_en && addr == 3'd4 && wdata[0])) |=> irq_tick);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4 && wdata[0] && !p0) |=> !irq_tick);
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (p2 && !(wr_en && addr == 3'd2)) |=> (cnt2 == $past(rld2)));
  a_r4_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    (!p2 && !(wr_en && addr == 3'd0)) |=> $stable(cnt0));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !(wr_en && addr == 3'd2)) |=> $stable(cnt2));
endmodule

bind tick_timer3 tick_timer3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .irq_tick(irq_tick),
  .p0(pulse_w[0]), .p2(pulse_w[2]),
  .cnt0(cnt_w[0]), .cnt2(cnt_w[2]), .rld2(rld_w[2])
);

// File: tb/tick_timer3_bench.sv
module tick_timer3_bench;
  localparam int CLK_P = 10;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq_tick, irq_base;
  int checks = 0, errors = 0;
  bit finished = 0;

  tick_timer3 u_tick_timer3 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_tick(irq_tick), .irq_base(irq_base));

  always #(CLK_P/2) clk = ~clk;

  // control byte: channel [7:6], access [5:4], mode [3:1]
  function automatic logic [7:0] ctl(input int ch, input logic [1:0] acc, input logic [2:0] md);
    return {2'(ch), acc, md, 1'b0};
  endfunction
  function automatic int cascade_len(input int d, input int n);
    return d * n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic load(input int ch, input int val);
    wr(3'd3, ctl(ch, 2'b11, 3'b010));
    wr(3'(ch), val[7:0]);
    wr(3'(ch), val[15:8]);
  endtask
  task automatic latch_read(input int ch, output int v);
    logic [7:0] lo, hi;
    wr(3'd3, ctl(ch, 2'b00, 3'b000));
    rd(3'(ch), lo); rd(3'(ch), hi);
    v = {hi, lo};
  endtask
  task automatic step(input int n);
    if (n > 0) begin
      @(negedge clk); tick_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, v2, d, n;
    logic [7:0] lo, hi;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check("R1 irq_tick", irq_tick, 0);
    check("R1 irq_base", irq_base, 0);
    latch_read(0, v); check("R1 count", v, 0);

    // R2 half-written count does not start
    wr(3'd3, ctl(2, 2'b11, 3'b010));
    wr(3'd2, 8'h05);
    step(3);
    latch_read(2, v); check("R2 before high byte", v, 0);
    wr(3'd2, 8'h00);
    latch_read(2, v); check("R2 loaded", v, 5);

    // R3 decrement and reload at 1
    step(3);
    latch_read(2, v); check("R3 decrement", v, 2);
    // R5 held latch survives counting and a second latch command
    wr(3'd3, ctl(2, 2'b00, 3'b000));
    step(1);
    wr(3'd3, ctl(2, 2'b00, 3'b000));
    rd(3'd2, lo); rd(3'd2, hi);
    check("R5 held snapshot", {hi, lo}, 2);
    latch_read(2, v); check("R5 fresh snapshot", v, 1);
    step(1);
    latch_read(2, v); check("R3 reload", v, 5);

    // R9 master enable low
    repeat (10) @(posedge clk);
    latch_read(2, v); check("R9 idle", v, 5);

    // R4 random cascade divisors
    for (int t = 0; t < 6; t++) begin
      d = 2 + int'($urandom % 5);
      n = 2 + int'($urandom % 9);
      load(2, d);
      load(0, n);
      wr(3'd4, 8'h03);
      step(cascade_len(d, n) - 1);
      check("R4 before terminal", irq_tick, 0);
      step(1);
      check("R4 at terminal", irq_tick, 1);
      step(d - 1);
      check("R7 sticky", irq_tick, 1);
    end

    // R7 clear patterns
    load(2, 2); load(0, 3); load(1, 2);
    step(12);
    check("R7 both set tick", irq_tick, 1);
    check("R7 both set base", irq_base, 1);
    wr(3'd4, 8'h01);
    check("R7 clear 01 tick", irq_tick, 0);
    check("R7 clear 01 base", irq_base, 1);
    wr(3'd4, 8'h02);
    check("R7 clear 02 base", irq_base, 0);
    step(12);
    wr(3'd4, 8'h03);
    check("R7 clear 03 tick", irq_tick, 0);
    check("R7 clear 03 base", irq_base, 0);

    // R7 set wins over simultaneous clear
    load(2, 2); load(0, 2);
    wr(3'd4, 8'h03);
    step(3);
    check("R7 no early pulse", irq_tick, 0);
    @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; addr = 3'd4; wdata = 8'h01;
    @(posedge clk);
    @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
    check("R7 set beats clear", irq_tick, 1);

    // R6 stop mode
    wr(3'd3, ctl(0, 2'b11, 3'b100));
    wr(3'd4, 8'h01);
    latch_read(0, v);
    step(20);
    latch_read(0, v2); check("R6 stopped count", v2, v);
    check("R6 no tick", irq_tick, 0);

    // R8 full-scale wrap on channel 1
    load(2, 2); load(1, 16'hFFFF);
    wr(3'd4, 8'h02);
    step(65535 * 2 - 1);
    check("R8 before wrap", irq_base, 0);
    step(1);
    check("R8 wrap", irq_base, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule